// File: doc/BRIEF.md
# PMP Region Bound Decoder

This block sits between the protection-entry configuration storage and the
access checker of a physical memory protection unit. For every entry it takes
the two-bit match mode, that entry's address register and the address register
of the entry just below it. From these it produces an inclusive start byte
address and an inclusive end byte address. The checker can then test an access
with two plain magnitude comparisons instead of decoding the encoded form on
every lookup. It also flags which entries are active and counts them, so that
the checker can skip disabled entries and spot the case where no entry is
enabled at all.

The decoder is purely combinational. Address registers are `XLEN` bits wide and
hold a byte address divided by four, so every bound it emits is `XLEN+2` bits
wide. The naturally aligned power-of-two form is decoded by counting the
trailing ones of the address register. An address register of all ones covers
the whole byte address space. The house style's state-machine layout has no
place here: there are no states and no transitions, only a per-entry mode
selection written as a `unique case` over a named enumeration.

Top module: `pmp_bound_decoder`

## Requirements
- R1: Mode codes are OFF=0, TOR (top of range)=1, NA4 (naturally aligned 4 bytes)=2 and NAPOT (naturally aligned power of two)=3. Entry i reads its mode from `mode_i[2i+1:2i]` and its address register from `addr_reg_i[XLEN*i +: XLEN]`. It drives its bounds on `start_o` and `end_o` at `[(XLEN+2)*i +: XLEN+2]` and its flag on `active_o[i]`.
- R2: In TOR mode, entry i>0 has start = addr_reg[i-1]<<2 and end = (addr_reg[i]<<2) - 1, computed modulo 2^(XLEN+2). A zero address register therefore gives an all-ones end.
- R3: In TOR mode, entry 0 uses zero as the previous address register, so its start is 0.
- R4: In NA4 mode, start = addr_reg<<2 and end = start + 3.
- R5: In NAPOT mode, with t trailing ones in an address register that is not all ones, start = (addr_reg with its low t bits cleared)<<2 and end = start + 2^(t+3) - 1.
- R6: In NAPOT mode, an all-ones address register gives start 0 and end equal to the all-ones byte address (2^(XLEN+2) - 1).
- R7: An OFF entry reports start 0 and an all-ones end, whatever its address registers hold.
- R8: `active_o[i]` is 1 exactly when entry i's mode is not OFF.
- R9: `active_cnt_o` equals the number of entries whose mode is not OFF. It spans 0 to NUM_ENTRIES inclusive.
- R10: All outputs depend only on the present inputs: a change on any input is visible at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2*NUM_ENTRIES | Packed two-bit match mode of every entry |
| addr_reg_i | input | XLEN*NUM_ENTRIES | Packed address registers (byte address divided by 4) |
| start_o | output | (XLEN+2)*NUM_ENTRIES | Packed inclusive start byte address of every entry |
| end_o | output | (XLEN+2)*NUM_ENTRIES | Packed inclusive end byte address of every entry |
| active_o | output | NUM_ENTRIES | One bit per entry, set when its mode is not OFF |
| active_cnt_o | output | $clog2(NUM_ENTRIES+1) | Number of active entries |

## Verification
The block holds no state, so a fault shows in the same cycle as the input pattern that exposes it. That pattern might be a wrong trailing-ones count, a mask cut off by one bit, a neighbour slice taken from the wrong entry or an adder that drops a carry. The bench therefore sets a new mode and address set on every clock and compares every bound, flag and the count against a behavioural model before the next change. Stimulus aims at the edges where such faults hide: zero registers in TOR, every trailing-ones length including none and the all-ones register, entry 0 with a nonzero neighbour that must be ignored, and the counts of zero and of every entry enabled.

// File: rtl/pmp_bound_pkg.sv
package pmp_bound_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

endpackage

// File: rtl/pmp_trailing_ones.sv
module pmp_trailing_ones #(
    parameter int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  value_i,
    output logic [CW-1:0] count_o
);

    // Scan upward from the LSB and stop at the first zero.
    always_comb begin
        logic seen_zero;
        seen_zero = 1'b0;
        count_o   = '0;
        for (int i = 0; i < W; i++) begin
            if (!seen_zero) begin
                if (value_i[i]) begin
                    count_o = CW'(i + 1);
                end else begin
                    seen_zero = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pmp_napot_range.sv
module pmp_napot_range #(
    parameter int XLEN = 32,
    localparam int BW  = XLEN + 2,
    localparam int CW  = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0] addr_reg_i,
    output logic [BW-1:0]   start_o,
    output logic [BW-1:0]   end_o
);

    logic [CW-1:0]   ones_cnt;
    logic [XLEN-1:0] clear_mask;
    logic [XLEN-1:0] span_mask;

    pmp_trailing_ones #(.W(XLEN)) u_tone (
        .value_i (addr_reg_i),
        .count_o (ones_cnt)
    );

    // clear_mask covers the t trailing ones; span_mask also covers the first
    // zero above them, which together with the two implied byte bits gives
    // a size of 2^(t+3).
    for (genvar g = 0; g < XLEN; g++) begin : g_mask
        assign clear_mask[g] = (ones_cnt >  CW'(g));
        assign span_mask[g]  = (ones_cnt >= CW'(g));
    end

    logic [XLEN-1:0] base_reg;
    assign base_reg = addr_reg_i & ~clear_mask;

    always_comb begin
        start_o = {base_reg, 2'b00};
        end_o   = {base_reg | span_mask, 2'b11};
    end

    always_comb begin
        // R5
        napot_align_chk: assert ((start_o & (start_o ^ end_o)) == '0)
            else $error("napot start not aligned to its size");
        // R5
        napot_span_chk: assert ($onehot0((start_o ^ end_o) + BW'(1)))
            else $error("napot span is not a power of two");
    end

endmodule

// File: rtl/pmp_entry_bounds.sv
module pmp_entry_bounds
    import pmp_bound_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int BW  = XLEN + 2
) (
    input  logic [1:0]      mode_i,
    input  logic [XLEN-1:0] addr_reg_i,
    input  logic [XLEN-1:0] prev_reg_i,
    output logic [BW-1:0]   start_o,
    output logic [BW-1:0]   end_o,
    output logic            active_o
);

    match_mode_e mode;
    logic [BW-1:0] napot_start;
    logic [BW-1:0] napot_end;
    logic [BW-1:0] this_byte;
    logic [BW-1:0] prev_byte;

    assign mode      = match_mode_e'(mode_i);
    assign this_byte = {addr_reg_i, 2'b00};
    assign prev_byte = {prev_reg_i, 2'b00};

    pmp_napot_range #(.XLEN(XLEN)) u_napot (
        .addr_reg_i (addr_reg_i),
        .start_o    (napot_start),
        .end_o      (napot_end)
    );

    always_comb begin
        active_o = 1'b1;
        unique case (mode)
            MATCH_OFF: begin
                start_o  = '0;
                end_o    = '1;
                active_o = 1'b0;
            end
            MATCH_TOR: begin
                start_o = prev_byte;
                end_o   = this_byte - BW'(1);
            end
            MATCH_NA4: begin
                start_o = this_byte;
                end_o   = this_byte + BW'(3);
            end
            MATCH_NAPOT: begin
                start_o = napot_start;
                end_o   = napot_end;
            end
            default: begin
                start_o  = '0;
                end_o    = '1;
                active_o = 1'b0;
            end
        endcase
    end

    always_comb begin
        // R4
        na4_size_chk: assert (mode != MATCH_NA4 || (end_o - start_o) == BW'(3))
            else $error("na4 region is not four bytes");
        // R2
        tor_word_chk: assert (mode != MATCH_TOR ||
                              (start_o[1:0] == 2'b00 && end_o[1:0] == 2'b11))
            else $error("tor bounds not word aligned");
        // R7
        off_full_chk: assert (active_o || (start_o == '0 && &end_o))
            else $error("off entry does not report full range");
    end

endmodule

// File: rtl/pmp_active_count.sv
module pmp_active_count #(
    parameter int N   = 8,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  active_i,
    output logic [CW-1:0] count_o
);

    always_comb begin
        count_o = '0;
        for (int i = 0; i < N; i++) begin
            count_o = count_o + CW'(active_i[i]);
        end
    end

endmodule

// File: rtl/pmp_bound_decoder.sv
module pmp_bound_decoder #(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 8,
    localparam int BW         = XLEN + 2,
    localparam int CW         = $clog2(NUM_ENTRIES + 1)
) (
    input  logic [2*NUM_ENTRIES-1:0]    mode_i,
    input  logic [XLEN*NUM_ENTRIES-1:0] addr_reg_i,
    output logic [BW*NUM_ENTRIES-1:0]   start_o,
    output logic [BW*NUM_ENTRIES-1:0]   end_o,
    output logic [NUM_ENTRIES-1:0]      active_o,
    output logic [CW-1:0]               active_cnt_o
);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic [XLEN-1:0] prev_reg;
        if (e == 0) begin : g_first
            assign prev_reg = '0;
        end else begin : g_rest
            assign prev_reg = addr_reg_i[XLEN*(e-1) +: XLEN];
        end

        pmp_entry_bounds #(.XLEN(XLEN)) u_bounds (
            .mode_i     (mode_i[2*e +: 2]),
            .addr_reg_i (addr_reg_i[XLEN*e +: XLEN]),
            .prev_reg_i (prev_reg),
            .start_o    (start_o[BW*e +: BW]),
            .end_o      (end_o[BW*e +: BW]),
            .active_o   (active_o[e])
        );
    end

    pmp_active_count #(.N(NUM_ENTRIES)) u_count (
        .active_i (active_o),
        .count_o  (active_cnt_o)
    );

    always_comb begin
        // R9
        active_cnt_chk: assert (active_cnt_o == CW'($countones(active_o)))
            else $error("active count disagrees with flags");
        // R3
        first_tor_chk: assert (mode_i[1:0] != 2'd1 || start_o[BW-1:0] == '0)
            else $error("entry 0 tor start not zero");
    end

endmodule

// File: tb/pmp_bound_decoder_tb.sv
module pmp_bound_decoder_tb;

    localparam int XLEN = 32;
    localparam int N    = 8;
    localparam int BW   = XLEN + 2;
    localparam int CW   = $clog2(N + 1);
    localparam longint BMASK = (64'd1 <<< BW) - 64'd1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [2*N-1:0]    mode;
    logic [XLEN*N-1:0] areg;
    logic [BW*N-1:0]   start_w;
    logic [BW*N-1:0]   end_w;
    logic [N-1:0]      act_w;
    logic [CW-1:0]     cnt_w;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pmp_bound_decoder #(.XLEN(XLEN), .NUM_ENTRIES(N)) u_dut (
        .mode_i       (mode),
        .addr_reg_i   (areg),
        .start_o      (start_w),
        .end_o        (end_w),
        .active_o     (act_w),
        .active_cnt_o (cnt_w)
    );

    // Reference bounds from the requirements (R1 field layout is used for slicing).
    function automatic void model(input int m, input longint a, input longint p,
                                  output longint s, output longint en);
        int t;
        case (m)
            0: begin s = 0; en = BMASK; end
            1: begin s = p * 4; en = (a * 4 - 1) & BMASK; end
            2: begin s = a * 4; en = a * 4 + 3; end
            default: begin
                t = 0;
                while (t < XLEN && ((a >> t) & 1) == 1) t++;
                if (t == XLEN) begin s = 0; en = BMASK; end
                else begin
                    s  = ((a >> t) << t) * 4;
                    en = s + (64'd1 <<< (t + 3)) - 1;
                end
            end
        endcase
    endfunction

    function automatic string tag_of(int m, int e, longint a);
        case (m)
            0: return "R7";
            1: return (e == 0) ? "R3" : "R2";
            2: return "R4";
            default: return (a == 64'hFFFF_FFFF) ? "R6" : "R5";
        endcase
    endfunction

    task automatic cmp(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Outputs are sampled in the same cycle the inputs changed (R10).
    task automatic check_all();
        int nact;
        nact = 0;
        for (int e = 0; e < N; e++) begin
            int m;
            longint a, p, s, en;
            m = int'(mode[2*e +: 2]);
            a = longint'(areg[XLEN*e +: XLEN]);
            p = (e == 0) ? 0 : longint'(areg[XLEN*(e-1) +: XLEN]);
            model(m, a, p, s, en);
            cmp(tag_of(m, e, a), $sformatf("start[%0d]", e), longint'(start_w[BW*e +: BW]), s);
            cmp(tag_of(m, e, a), $sformatf("end[%0d]", e), longint'(end_w[BW*e +: BW]), en);
            cmp("R8", $sformatf("active[%0d]", e), longint'(act_w[e]), (m != 0) ? 1 : 0);
            if (m != 0) nact++;
        end
        cmp("R9", "count", longint'(cnt_w), longint'(nact));
    endtask

    function automatic logic [XLEN-1:0] napot_val(int t);
        logic [XLEN-1:0] v;
        v = $urandom;
        if (t >= XLEN) return '1;
        for (int b = 0; b < t; b++) v[b] = 1'b1;
        v[t] = 1'b0;
        return v;
    endfunction

    task automatic apply(logic [2*N-1:0] m, logic [XLEN*N-1:0] a);
        @(posedge clk);
        #1;
        mode = m;
        areg = a;
        @(negedge clk);
        check_all();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0]    m;
        logic [XLEN*N-1:0] a;
        mode = '0;
        areg = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Initial state: all OFF, count 0 (R7, R8, R9).
        check_all();

        // R7: OFF ignores nonzero address registers.
        apply('0, {N{32'hDEAD_BEEF}});
        // R3: entry 0 TOR with neighbour data present; R2: zero register wraps.
        a = '0;
        a[31:0]  = 32'h0000_0100;
        a[63:32] = 32'h0000_0000;
        a[95:64] = 32'h1234_5678;
        apply({{(N-3){2'd0}}, 2'd1, 2'd1, 2'd1}, a);
        // R4: NA4 on every entry, including top register value.
        a = '0;
        for (int e = 0; e < N; e++) a[XLEN*e +: XLEN] = (e == N-1) ? 32'hFFFF_FFFF : 32'h10 * (e + 1);
        apply({N{2'd2}}, a);
        // R5: every trailing-ones length; R6: all ones.
        for (int t = 0; t <= XLEN; t++) begin
            a = '0;
            for (int e = 0; e < N; e++) a[XLEN*e +: XLEN] = napot_val(t);
            apply({N{2'd3}}, a);
        end
        // R9: count at every level from 0 to N.
        for (int k = 0; k <= N; k++) begin
            m = '0;
            for (int e = 0; e < k; e++) m[2*e +: 2] = 2'(1 + (e % 3));
            a = '0;
            for (int e = 0; e < N; e++) a[XLEN*e +: XLEN] = $urandom;
            apply(m, a);
        end
        // Mixed random patterns, with NAPOT values biased toward structure (R2..R8).
        for (int it = 0; it < 3000; it++) begin
            for (int e = 0; e < N; e++) begin
                m[2*e +: 2] = 2'($urandom_range(0, 3));
                case ($urandom_range(0, 3))
                    0: a[XLEN*e +: XLEN] = napot_val($urandom_range(0, XLEN));
                    1: a[XLEN*e +: XLEN] = '0;
                    default: a[XLEN*e +: XLEN] = $urandom;
                endcase
            end
            apply(m, a);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule